// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a configuration bitstream into an attached FPGA over a bit-serial slave link. A pulse on `start` begins the sequence. The loader holds the target's program line low with the clock and data lines high, then waits for the target's init line to fall. It releases the program line and waits for init to rise again. Each wait has a bounded timeout.

Once the target is ready, bytes arrive on a valid/ready stream. The loader throws bytes away until it finds a run of consecutive 0xFF bytes, which marks the start of configuration data. The run itself is sent, and so is every byte after it, most significant bit first. After the byte flagged `in_last`, a fixed number of 0xFF padding bytes are clocked out. The loader then waits, again with a timeout, for the target's done line.

The result is reported on `done_ok` or on a 2-bit error code. Either value stays until the next start.

The time base is a prescaler that divides the system clock into millisecond ticks. A timeout fires when a wait has lasted `TIMEOUT_TICKS` ticks.

Top module: `serial_cfg_loader`

## Requirements
- R1: After `start` is taken in the idle state, `prog_n` is 0 and `busy` is 1, while `cclk` and `din` are both 1.
- R2: If `init_in` stays 1 while `prog_n` is low, then `TICK_DIV*TIMEOUT_TICKS` clock edges after the start edge the block returns to idle with `err_code` = 1 and `prog_n` = 1.
- R3: If `init_in` does not return to 1 after `prog_n` is released, the block times out with `err_code` = 2.
- R4: Bytes before the first run of `PREAMBLE_LEN` consecutive 0xFF bytes are discarded. A run broken by any other byte does not count. The run's own bytes are transmitted.
- R5: Every transmitted byte is sent most significant bit first. Each bit value is the level of `din` when `cclk` rises.
- R6: A bit has four phases, each `HALF_CYC` cycles long, in this order: clock low with data 1, clock low with data set to the bit, clock high with the bit, clock high with data 1. The low time is `2*HALF_CYC` cycles, and `din` is 1 whenever `cclk` falls.
- R7: `in_ready` is 1 only while scanning for the preamble or sending data, and only when no bit is in flight. It is never 1 while `cclk` is low or `prog_n` is low.
- R8: After the byte marked `in_last` is sent, exactly `PAD_BYTES` bytes of 0xFF follow.
- R9: After padding, `done_in` = 1 ends the run with `done_ok` = 1. A timeout in that wait gives `err_code` = 3.
- R10: When the awaited condition on `init_in` or `done_in` appears in the same cycle that the timeout expires, the condition wins and no error is recorded.
- R11: `err_code` and `done_ok` keep their values until the next `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (acted on only when idle) |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Byte stream ready |
| init_in | input | 1 | Target init status line |
| done_in | input | 1 | Target configuration-complete line |
| prog_n | output | 1 | Target program line, active low |
| cclk | output | 1 | Serial configuration clock |
| din | output | 1 | Serial configuration data |
| busy | output | 1 | A load sequence is in progress |
| done_ok | output | 1 | Last load finished successfully |
| err_code | output | 2 | 0 none, 1 init stuck high, 2 init stuck low, 3 done missing |

## Verification
Two events can fall in the same cycle: a handshake wait meeting its condition, and that wait's timeout expiring. The bench provokes the collision by starting a load and counting `TICK_DIV*TIMEOUT_TICKS-1` edges. It then drops `init_in` in exactly the cycle in which the expiry is decoded. The run is correct if, after the next edge, `err_code` is still 0, `busy` is still 1 and `prog_n` has been released, which shows the condition took priority.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    ERR_NONE          = 2'd0,
    ERR_INIT_STUCK_HI = 2'd1,
    ERR_INIT_STUCK_LO = 2'd2,
    ERR_NO_DONE       = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_INIT_REL,
    ST_SCAN,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_DONE_WAIT
  } st_e;

  // Levels {cclk, din} for one of the four bit phases.
  function automatic logic [1:0] phase_level(input logic [1:0] ph, input logic b);
    case (ph)
      2'd0:    return 2'b01;
      2'd1:    return {1'b0, b};
      2'd2:    return {1'b1, b};
      default: return 2'b11;
    endcase
  endfunction

  // Length of the 0xFF run after one more byte.
  function automatic int run_next(input int run, input logic [7:0] b);
    return (b == 8'hFF) ? run + 1 : 0;
  endfunction

  // Clock edges from entering a wait until its error is registered.
  function automatic int timeout_cycles(input int div, input int ticks);
    return div * ticks;
  endfunction

endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int TICK_DIV      = 50000,
  parameter int TIMEOUT_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] ticks_q;
  logic          tick;

  assign tick   = run && (pre_q == PW'(TICK_DIV - 1));
  assign expire = tick && (ticks_q == TW'(TIMEOUT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else if (clear || !run) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else if (tick) begin
      pre_q   <= '0;
      ticks_q <= ticks_q + 1'b1;
    end else begin
      pre_q   <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgld_scan.sv
module cfgld_scan import cfgld_pkg::*; #(
  parameter int PREAMBLE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  logic [7:0] byte_in,
  output logic       found
);
  localparam int RW = (PREAMBLE_LEN > 1) ? $clog2(PREAMBLE_LEN) : 1;

  logic [RW-1:0] run_q;

  assign found = take && (byte_in == 8'hFF) && (run_q == RW'(PREAMBLE_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (clear)   run_q <= '0;
    else if (take) begin
      if (found) run_q <= '0;
      else       run_q <= RW'(run_next(int'(run_q), byte_in));
    end
  end
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter import cfgld_pkg::*; #(
  parameter int HALF_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       idle,
  output logic       cclk,
  output logic       din
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          active_q;
  logic [1:0]    ph_q;
  logic [HW-1:0] hc_q;
  logic [2:0]    idx_q;
  logic [7:0]    sr_q;
  logic [1:0]    lv_q;

  assign idle = !active_q;
  assign cclk = lv_q[1];
  assign din  = lv_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      hc_q     <= '0;
      idx_q    <= '0;
      sr_q     <= '0;
      lv_q     <= 2'b11;
    end else if (load && !active_q) begin
      active_q <= 1'b1;
      ph_q     <= 2'd0;
      hc_q     <= '0;
      idx_q    <= '0;
      sr_q     <= byte_in;
      lv_q     <= phase_level(2'd0, byte_in[7]);
    end else if (active_q) begin
      if (hc_q == HW'(HALF_CYC - 1)) begin
        hc_q <= '0;
        if (ph_q == 2'd3) begin
          if (idx_q == 3'd7) begin
            active_q <= 1'b0;
            lv_q     <= 2'b11;
          end else begin
            idx_q <= idx_q + 1'b1;
            sr_q  <= {sr_q[6:0], 1'b0};
            ph_q  <= 2'd0;
            lv_q  <= phase_level(2'd0, sr_q[6]);
          end
        end else begin
          ph_q <= ph_q + 1'b1;
          lv_q <= phase_level(ph_q + 2'd1, sr_q[7]);
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader import cfgld_pkg::*; #(
  parameter int TICK_DIV      = 50000,
  parameter int TIMEOUT_TICKS = 4,
  parameter int HALF_CYC      = 1,
  parameter int PAD_BYTES     = 8,
  parameter int PREAMBLE_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       init_in,
  input  logic       done_in,
  output logic       prog_n,
  output logic       cclk,
  output logic       din,
  output logic       busy,
  output logic       done_ok,
  output logic [1:0] err_code
);
  localparam int PEND_MAX = (PAD_BYTES > PREAMBLE_LEN) ? PAD_BYTES : PREAMBLE_LEN;
  localparam int NW       = $clog2(PEND_MAX + 1);

  st_e           state_q, state_d;
  logic [NW-1:0] pend_q, pend_d;
  logic          last_q, last_d;
  err_e          err_q, err_d;
  logic          ok_q, ok_d;

  // Named internal events, observed by the checker.
  logic       sh_idle;
  logic       sh_load;
  logic [7:0] sh_byte;
  logic       wait_run;
  logic       wait_met;
  logic       wait_expire;
  logic       timer_clr;
  logic       accept;
  logic       scan_take;
  logic       scan_found;

  assign wait_run = (state_q == ST_PROG) || (state_q == ST_INIT_REL) ||
                    (state_q == ST_DONE_WAIT);
  assign wait_met = ((state_q == ST_PROG)      && !init_in) ||
                    ((state_q == ST_INIT_REL)  &&  init_in) ||
                    ((state_q == ST_DONE_WAIT) &&  done_in);

  assign in_ready  = ((state_q == ST_SCAN) || (state_q == ST_DATA)) && sh_idle;
  assign accept    = in_ready && in_valid;
  assign scan_take = accept && (state_q == ST_SCAN);
  assign sh_byte   = (state_q == ST_DATA) ? in_data : 8'hFF;
  assign timer_clr = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    last_d  = last_q;
    err_d   = err_q;
    ok_d    = ok_q;
    sh_load = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_PROG;
        err_d   = ERR_NONE;
        ok_d    = 1'b0;
      end
      ST_PROG: begin
        if (wait_met)         state_d = ST_INIT_REL;
        else if (wait_expire) begin
          state_d = ST_IDLE;
          err_d   = ERR_INIT_STUCK_HI;
        end
      end
      ST_INIT_REL: begin
        if (wait_met)         state_d = ST_SCAN;
        else if (wait_expire) begin
          state_d = ST_IDLE;
          err_d   = ERR_INIT_STUCK_LO;
        end
      end
      ST_SCAN: if (scan_found) begin
        state_d = ST_PRE;
        pend_d  = NW'(PREAMBLE_LEN);
        last_d  = in_last;
      end
      ST_PRE: if (sh_idle) begin
        if (pend_q != '0) begin
          sh_load = 1'b1;
          pend_d  = pend_q - 1'b1;
        end else if (last_q) begin
          state_d = ST_PAD;
          pend_d  = NW'(PAD_BYTES);
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: if (accept) begin
        sh_load = 1'b1;
        if (in_last) begin
          state_d = ST_PAD;
          pend_d  = NW'(PAD_BYTES);
        end
      end
      ST_PAD: if (sh_idle) begin
        if (pend_q != '0) begin
          sh_load = 1'b1;
          pend_d  = pend_q - 1'b1;
        end else begin
          state_d = ST_DONE_WAIT;
        end
      end
      ST_DONE_WAIT: begin
        if (wait_met) begin
          state_d = ST_IDLE;
          ok_d    = 1'b1;
        end else if (wait_expire) begin
          state_d = ST_IDLE;
          err_d   = ERR_NO_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      last_q  <= 1'b0;
      err_q   <= ERR_NONE;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      last_q  <= last_d;
      err_q   <= err_d;
      ok_q    <= ok_d;
    end
  end

  cfgld_timer #(.TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clr), .run(wait_run), .expire(wait_expire)
  );

  cfgld_scan #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(state_q != ST_SCAN), .take(scan_take),
    .byte_in(in_data), .found(scan_found)
  );

  cfgld_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .byte_in(sh_byte),
    .idle(sh_idle), .cclk(cclk), .din(din)
  );

  assign busy     = (state_q != ST_IDLE);
  assign prog_n   = (state_q != ST_PROG);
  assign done_ok  = ok_q;
  assign err_code = err_q;
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_ready,
  input logic       prog_n,
  input logic       cclk,
  input logic       din,
  input logic       busy,
  input logic       done_ok,
  input logic [1:0] err_code,
  input logic       wait_met,
  input logic       wait_expire
);
  assert_prog_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (cclk && din && busy));

  // R2, R3 and R9: an unmet expiry always leaves an error code behind.
  assert_timeout_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_expire && !wait_met) |=> (err_code != 2'd0));

  assert_data_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $stable(din));

  assert_data_idle_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk) |-> din);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cclk && prog_n && busy));

  assert_result_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (err_code == 2'd0 && !busy));

  assert_met_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_met |=> (err_code == 2'd0));

  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0 && !start) |=> $stable(err_code));
endmodule

bind serial_cfg_loader cfgld_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .prog_n(prog_n), .cclk(cclk), .din(din), .busy(busy), .done_ok(done_ok),
  .err_code(err_code), .wait_met(wait_met), .wait_expire(wait_expire)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int TDIV = 5;
  localparam int TOUT = 4;
  localparam int HALF = 2;
  localparam int PADB = 8;
  localparam int PREL = 4;
  localparam int TD   = TDIV * TOUT;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic init_in = 1'b1, done_in = 1'b0;
  logic in_ready, prog_n, cclk, din, busy, done_ok;
  logic [1:0] err_code;

  int checks = 0, fails = 0, cycles = 0;
  int rise_count = 0, low_run = 0;
  logic prev_cclk = 1'b1;
  bit exp_q[$];

  always #2 clk = ~clk;

  serial_cfg_loader #(.TICK_DIV(TDIV), .TIMEOUT_TICKS(TOUT), .HALF_CYC(HALF),
                      .PAD_BYTES(PADB), .PREAMBLE_LEN(PREL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .init_in(init_in), .done_in(done_in),
    .prog_n(prog_n), .cclk(cclk), .din(din), .busy(busy), .done_ok(done_ok),
    .err_code(err_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Per-clock reference of the serial link: expected bit order and waveform.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cclk && !prev_cclk) begin
        rise_count++;
        check(low_run == 2 * HALF, "R6 low time", low_run, 2 * HALF);
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected bit", din, -1);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(din == e, "R5 bit value", din, e);
        end
        low_run = 0;
      end
      if (!cclk) begin
        if (prev_cclk) check(din == 1'b1, "R6 din at clock fall", din, 1);
        low_run++;
        if (in_ready) check(1'b0, "R7 ready during bit", in_ready, 0);
      end
      prev_cclk = cclk;
    end
  end

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic end_stream();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic target_handshake();
    while (prog_n) @(negedge clk);
    repeat (3) @(negedge clk);
    init_in = 1'b0;
    while (!prog_n) @(negedge clk);
    repeat (3) @(negedge clk);
    init_in = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    check(busy == 0 && prog_n == 1, "R1 reset idle", {busy, prog_n}, 1);
    check(cclk == 1 && din == 1, "R6 reset levels", {cclk, din}, 3);
    check(err_code == 0 && done_ok == 0 && in_ready == 0, "R11 reset result",
          {err_code, done_ok, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full load: leading junk and a broken run are discarded
    rise_count = 0;
    for (int k = 0; k < PREL; k++) push_byte(8'hFF);
    push_byte(8'hA5); push_byte(8'h3C);
    for (int k = 0; k < PADB; k++) push_byte(8'hFF);
    do_start();
    target_handshake();
    send_byte(8'h12, 0); send_byte(8'hFF, 0); send_byte(8'hFF, 0); send_byte(8'h00, 0);
    send_byte(8'hFF, 0); send_byte(8'hFF, 0); send_byte(8'hFF, 0); send_byte(8'hFF, 0);
    send_byte(8'hA5, 0); send_byte(8'h3C, 1);
    end_stream();
    wait_drained();
    repeat (2 * HALF) @(negedge clk);
    done_in = 1'b1;
    wait_idle();
    check(done_ok == 1 && err_code == 0, "R9 success", {done_ok, err_code}, 4);
    check(rise_count == 8 * (PREL + 2 + PADB), "R8 bit total", rise_count, 8 * (PREL + 2 + PADB));
    check(exp_q.size() == 0, "R4 stream consumed", exp_q.size(), 0);
    done_in = 1'b0;

    // Done never seen
    rise_count = 0;
    for (int k = 0; k < PREL + PADB; k++) push_byte(8'hFF);
    do_start();
    check(done_ok == 0, "R11 start clears ok", done_ok, 0);
    target_handshake();
    for (int k = 0; k < PREL; k++) send_byte(8'hFF, (k == PREL - 1));
    end_stream();
    wait_idle();
    check(err_code == 3 && done_ok == 0, "R9 done timeout", err_code, 3);
    check(rise_count == 8 * (PREL + PADB), "R8 pad after preamble", rise_count, 8 * (PREL + PADB));
    repeat (10) @(negedge clk);
    check(err_code == 3, "R11 error held", err_code, 3);

    // Init stuck high, timed exactly
    do_start();
    check(err_code == 0, "R11 start clears error", err_code, 0);
    check(prog_n == 0 && cclk == 1 && din == 1 && busy == 1, "R1 program pulse",
          {prog_n, cclk, din, busy}, 7);
    check(in_ready == 0, "R7 no ready in handshake", in_ready, 0);
    repeat (TD - 1) @(posedge clk);
    @(negedge clk);
    check(err_code == 0 && busy == 1, "R2 not before limit", err_code, 0);
    @(posedge clk); @(negedge clk);
    check(err_code == 1 && busy == 0 && prog_n == 1, "R2 init stuck high", err_code, 1);

    // Init never returns high
    do_start();
    init_in = 1'b0;
    wait_idle();
    check(err_code == 2 && prog_n == 1, "R3 init stuck low", err_code, 2);

    // Collision: init falls in the expiry cycle
    init_in = 1'b1;
    do_start();
    repeat (TD - 1) @(posedge clk);
    @(negedge clk); init_in = 1'b0;
    @(posedge clk); @(negedge clk);
    check(err_code == 0 && busy == 1 && prog_n == 1, "R10 condition wins",
          {err_code, busy, prog_n}, 3);
    repeat (2) @(negedge clk);
    init_in = 1'b1;
    rise_count = 0;
    for (int k = 0; k < PREL + PADB; k++) push_byte(8'hFF);
    for (int k = 0; k < PREL; k++) send_byte(8'hFF, (k == PREL - 1));
    end_stream();
    done_in = 1'b1;
    wait_idle();
    check(done_ok == 1 && err_code == 0, "R9 success after collision", done_ok, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule